// File: doc/BRIEF.md
# Saturating-Age LRU Replacement Unit

This block keeps the replacement state for every set of a set-associative cache and decides which way a miss should overwrite. Each way of each set carries a small age counter. The number of age states, U, is set by a parameter and may be 2, 3 or 4. The youngest (most recently used) way holds U-1 and the oldest holds 0. The ages stay inside the block in a register array indexed by set. Tag comparison is done elsewhere and arrives here as a hit way number.

Each cycle the cache presents a set index together with at most one operation: a hit on a given way, a fill (a miss refill, which may be marked as failed), or an invalidate of a given way. In the same cycle the block shows the victim way for that set and the updated ages. The updated ages are written into the array on the closing clock edge. Every operation completes in one cycle, so there is no back-pressure and no handshake. A caller may present a new operation on every cycle, including on the set that was updated on the previous edge.

The policy is an approximate LRU. A hit ages only the ways that are younger than the hit way. A fill ages every way whose age is not zero.

Top module: `lru_age_repl`

## Requirements
- R1: After reset every age of every set is 0, so `ages_out` reads all zeros and `victim_way` is 0 for any set index.
- R2: A hit (hit_en=1, inv_en=0) sets the hit way's age to U-1. It lowers by one every other way whose age is strictly greater than the hit way's old age. All remaining ways keep their age.
- R3: A successful fill (fill_en=1, fill_fail=0, hit_en=0, inv_en=0) sets the age of the victim way to U-1. It lowers by one every other way whose age is nonzero.
- R4: `victim_way` is the way with the smallest current age of the indexed set. When several ways share that age, the lowest-numbered of them is chosen.
- R5: An invalidate (inv_en=1) sets the age of `inv_way` to 0 and leaves every other way unchanged. In the same cycle it overrides any hit or fill.
- R6: A failed fill (fill_en=1, fill_fail=1, no hit, no invalidate) sets the victim way's age to 0. It leaves every other way unchanged.
- R7: Every age always stays within 0 to U-1.
- R8: The updated ages are stored on the clock edge that ends the operation, and they are seen on the next access to that set. Sets other than the indexed set are never changed.
- R9: With no operation asserted, `ages_out` shows the stored ages of the indexed set unchanged. Way w occupies bits [w*AW +: AW] of `ages_out`, where AW is 1 for U=2 and 2 for U=3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all ages |
| set_idx | input | log2(NUM_SETS) | Set addressed this cycle |
| hit_en | input | 1 | Hit on `hit_way` |
| hit_way | input | log2(NUM_WAYS) | Way that matched |
| fill_en | input | 1 | Miss refill into `victim_way` |
| fill_fail | input | 1 | Qualifies `fill_en`: the refill failed |
| inv_en | input | 1 | Invalidate `inv_way` |
| inv_way | input | log2(NUM_WAYS) | Way to invalidate |
| victim_way | output | log2(NUM_WAYS) | Replacement choice for the indexed set |
| ages_out | output | NUM_WAYS*AW | Updated ages of the indexed set, way-packed |

## Verification
The assertions assume that hit_en and fill_en are never both high in the same cycle. The block still resolves that case by giving the hit priority. The assertions also assume that fill_fail only means something while fill_en is high. The stimulus drives hit and fill from one operation choice, so the two can never coincide. It does raise an invalidate on top of a hit or a fill, to exercise the override. The victim-order check runs only on idle cycles, when `ages_out` still equals the stored ages.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HIT,
    ACT_FILL,
    ACT_FILL_FAIL,
    ACT_INV
  } act_e;

  // Invalidate wins, then hit, then fill.
  function automatic act_e decode_act(input logic hit, input logic fill,
                                      input logic fail, input logic inv);
    if (inv)  return ACT_INV;
    if (hit)  return ACT_HIT;
    if (fill) return fail ? ACT_FILL_FAIL : ACT_FILL;
    return ACT_NONE;
  endfunction

endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic [WAY_W-1:0]      victim
);
  logic [AGE_W-1:0] best;

  // Strict compare keeps the lowest index on ties.
  always_comb begin
    best   = ages[0 +: AGE_W];
    victim = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (ages[w*AGE_W +: AGE_W] < best) begin
        best   = ages[w*AGE_W +: AGE_W];
        victim = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/lru_age_update.sv
module lru_age_update
  import lru_age_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  parameter int AGE_STATES = 3,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS*AGE_W-1:0] cur_ages,
  input  act_e                  act,
  input  logic [WAY_W-1:0]      hit_way,
  input  logic [WAY_W-1:0]      inv_way,
  input  logic [WAY_W-1:0]      victim,
  output logic [WAYS*AGE_W-1:0] nxt_ages
);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_STATES - 1);

  logic [AGE_W-1:0] hit_age;
  assign hit_age = cur_ages[hit_way*AGE_W +: AGE_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    localparam logic [WAY_W-1:0] IDX = WAY_W'(g);
    logic [AGE_W-1:0] age_q;
    logic [AGE_W-1:0] age_d;
    assign age_q = cur_ages[g*AGE_W +: AGE_W];

    always_comb begin
      age_d = age_q;
      unique case (act)
        ACT_INV: begin
          if (inv_way == IDX) age_d = '0;
        end
        ACT_HIT: begin
          if (hit_way == IDX)        age_d = AGE_TOP;
          else if (age_q > hit_age)  age_d = age_q - 1'b1;
        end
        ACT_FILL: begin
          if (victim == IDX)         age_d = AGE_TOP;
          else if (age_q != '0)      age_d = age_q - 1'b1;
        end
        ACT_FILL_FAIL: begin
          if (victim == IDX)         age_d = '0;
        end
        default: age_d = age_q;
      endcase
    end

    assign nxt_ages[g*AGE_W +: AGE_W] = age_d;
  end
endmodule

// File: rtl/lru_age_store.sv
module lru_age_store #(
  parameter int SETS  = 16,
  parameter int WORD_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [SETS];

  assign rd_word = mem[set_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) mem[s] <= '0;
    end else if (wr_en) begin
      mem[set_sel] <= wr_word;
    end
  end
endmodule

// File: rtl/lru_age_repl.sv
module lru_age_repl
  import lru_age_pkg::*;
#(
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 4,
  parameter int AGE_STATES = 3,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int AGE_W = (AGE_STATES > 2) ? 2 : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SET_W-1:0]          set_idx,
  input  logic                      hit_en,
  input  logic [WAY_W-1:0]          hit_way,
  input  logic                      fill_en,
  input  logic                      fill_fail,
  input  logic                      inv_en,
  input  logic [WAY_W-1:0]          inv_way,
  output logic [WAY_W-1:0]          victim_way,
  output logic [NUM_WAYS*AGE_W-1:0] ages_out
);
  if (AGE_STATES < 2 || AGE_STATES > 4) begin : g_bad_states
    $error("AGE_STATES must lie between 2 and 4");
  end

  act_e                      act;
  logic [NUM_WAYS*AGE_W-1:0] cur_ages;
  logic [NUM_WAYS*AGE_W-1:0] nxt_ages;
  logic [WAY_W-1:0]          victim;

  assign act = decode_act(hit_en, fill_en, fill_fail, inv_en);

  lru_age_store #(
    .SETS   (NUM_SETS),
    .WORD_W (NUM_WAYS*AGE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_sel (set_idx),
    .wr_en   (act != ACT_NONE),
    .wr_word (nxt_ages),
    .rd_word (cur_ages)
  );

  lru_victim_pick #(
    .WAYS  (NUM_WAYS),
    .AGE_W (AGE_W)
  ) u_pick (
    .ages   (cur_ages),
    .victim (victim)
  );

  lru_age_update #(
    .WAYS       (NUM_WAYS),
    .AGE_W      (AGE_W),
    .AGE_STATES (AGE_STATES)
  ) u_upd (
    .cur_ages (cur_ages),
    .act      (act),
    .hit_way  (hit_way),
    .inv_way  (inv_way),
    .victim   (victim),
    .nxt_ages (nxt_ages)
  );

  assign victim_way = victim;
  assign ages_out   = nxt_ages;
endmodule

// File: rtl/lru_age_repl_chk.sv
module lru_age_repl_chk #(
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 4,
  parameter int AGE_STATES = 3,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int AGE_W = (AGE_STATES > 2) ? 2 : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SET_W-1:0]          set_idx,
  input logic                      hit_en,
  input logic [WAY_W-1:0]          hit_way,
  input logic                      fill_en,
  input logic                      fill_fail,
  input logic                      inv_en,
  input logic [WAY_W-1:0]          inv_way,
  input logic [WAY_W-1:0]          victim_way,
  input logic [NUM_WAYS*AGE_W-1:0] ages_out
);
  localparam logic [AGE_W-1:0] TOP = AGE_W'(AGE_STATES - 1);

  logic idle;
  logic armed;
  logic bounds_ok;
  logic order_ok;
  logic [AGE_W-1:0] vic_age;

  assign idle    = !hit_en && !fill_en && !inv_en;
  assign vic_age = ages_out[victim_way*AGE_W +: AGE_W];

  always_comb begin
    bounds_ok = 1'b1;
    order_ok  = 1'b1;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (ages_out[w*AGE_W +: AGE_W] > TOP) bounds_ok = 1'b0;
      if (ages_out[w*AGE_W +: AGE_W] < vic_age) order_ok = 1'b0;
      if (WAY_W'(w) < victim_way && ages_out[w*AGE_W +: AGE_W] == vic_age)
        order_ok = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  hit_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !inv_en) |-> ages_out[hit_way*AGE_W +: AGE_W] == TOP)
    else $error("hit way not youngest");

  // R3
  fill_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_fail && !hit_en && !inv_en)
      |-> ages_out[victim_way*AGE_W +: AGE_W] == TOP)
    else $error("filled way not youngest");

  // R4
  victim_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> order_ok)
    else $error("victim not oldest lowest way");

  // R5
  inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> ages_out[inv_way*AGE_W +: AGE_W] == '0)
    else $error("invalidated way not cleared");

  // R6
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_fail && !hit_en && !inv_en)
      |-> ages_out[victim_way*AGE_W +: AGE_W] == '0)
    else $error("failed fill way not cleared");

  // R7
  age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bounds_ok)
    else $error("age out of range");

  // R8
  write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && idle && set_idx == $past(set_idx)) |-> ages_out == $past(ages_out))
    else $error("stored ages differ from last result");
endmodule

bind lru_age_repl lru_age_repl_chk #(
  .NUM_SETS   (NUM_SETS),
  .NUM_WAYS   (NUM_WAYS),
  .AGE_STATES (AGE_STATES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_idx    (set_idx),
  .hit_en     (hit_en),
  .hit_way    (hit_way),
  .fill_en    (fill_en),
  .fill_fail  (fill_fail),
  .inv_en     (inv_en),
  .inv_way    (inv_way),
  .victim_way (victim_way),
  .ages_out   (ages_out)
);

// File: tb/tb_lru_age_repl.sv
`timescale 1ns/1ps
module tb_lru_age_repl;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int U    = 3;
  localparam int AW   = 2;
  localparam int WW   = 2;
  localparam int SW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] set_idx = '0;
  logic          hit_en = 1'b0;
  logic [WW-1:0] hit_way = '0;
  logic          fill_en = 1'b0;
  logic          fill_fail = 1'b0;
  logic          inv_en = 1'b0;
  logic [WW-1:0] inv_way = '0;
  logic [WW-1:0] victim_way;
  logic [WAYS*AW-1:0] ages_out;

  always #2.5 clk = ~clk;

  lru_age_repl #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .AGE_STATES(U)) dut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_en(hit_en),
    .hit_way(hit_way), .fill_en(fill_en), .fill_fail(fill_fail),
    .inv_en(inv_en), .inv_way(inv_way), .victim_way(victim_way),
    .ages_out(ages_out)
  );

  int checks = 0;
  int failures = 0;
  int mdl [SETS][WAYS];

  logic [WAYS*AW-1:0] exp_ages_q [$];
  logic [WW-1:0]      exp_vic_q  [$];
  string              tag_q      [$];

  function automatic int pick_victim(int s);
    int v = 0;
    for (int w = 1; w < WAYS; w++) if (mdl[s][w] < mdl[s][v]) v = w;
    return v;
  endfunction

  task automatic step(input int s, input bit h, input int hw, input bit f,
                      input bit ff, input bit iv, input int iw, input string tag);
    int nxt [WAYS];
    int v;
    logic [WAYS*AW-1:0] packed_exp;
    @(negedge clk);
    set_idx = SW'(s); hit_en = h; hit_way = WW'(hw); fill_en = f;
    fill_fail = ff; inv_en = iv; inv_way = WW'(iw);
    v = pick_victim(s);
    for (int w = 0; w < WAYS; w++) nxt[w] = mdl[s][w];
    if (iv) begin
      nxt[iw] = 0;
    end else if (h) begin
      for (int w = 0; w < WAYS; w++)
        if (w != hw && mdl[s][w] > mdl[s][hw]) nxt[w] = mdl[s][w] - 1;
      nxt[hw] = U - 1;
    end else if (f && ff) begin
      nxt[v] = 0;
    end else if (f) begin
      for (int w = 0; w < WAYS; w++)
        if (w != v && mdl[s][w] != 0) nxt[w] = mdl[s][w] - 1;
      nxt[v] = U - 1;
    end
    for (int w = 0; w < WAYS; w++) packed_exp[w*AW +: AW] = AW'(nxt[w]);
    exp_ages_q.push_back(packed_exp);
    exp_vic_q.push_back(WW'(v));
    tag_q.push_back(tag);
    for (int w = 0; w < WAYS; w++) mdl[s][w] = nxt[w];
  endtask

  task automatic idle_on(input int s, input string tag);
    step(s, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare each cycle's outputs against the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (tag_q.size() > 0) begin
        logic [WAYS*AW-1:0] ea;
        logic [WW-1:0] ev;
        string t;
        ea = exp_ages_q.pop_front();
        ev = exp_vic_q.pop_front();
        t  = tag_q.pop_front();
        checks++;
        if (ages_out !== ea || victim_way !== ev) begin
          failures++;
          $display("FAIL %s ages=%h victim=%0d expected ages=%h victim=%0d",
                   t, ages_out, victim_way, ea, ev);
        end
        // R7: each field within 0..U-1
        checks++;
        for (int w = 0; w < WAYS; w++) begin
          if (ages_out[w*AW +: AW] > AW'(U-1)) begin
            failures++;
            $display("FAIL R7 way %0d age=%0d expected <= %0d", w,
                     ages_out[w*AW +: AW], U-1);
            break;
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) mdl[s][w] = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    idle_on(0, "R1 reset set0");
    idle_on(5, "R1 reset set5");

    // Fills on set 1: victim order and tie to lowest way.
    step(1, 0, 0, 1, 0, 0, 0, "R3 fill empty set");
    step(1, 0, 0, 1, 0, 0, 0, "R3 second fill");
    step(1, 0, 0, 1, 0, 0, 0, "R4 tie lowest way");
    step(1, 0, 0, 1, 0, 0, 0, "R3 fill wraps");
    idle_on(1, "R8 stored after fills");
    idle_on(2, "R8 other set untouched");

    // Hits: only younger ways age.
    step(1, 1, 3, 0, 0, 0, 0, "R2 hit oldest way");
    step(1, 1, 3, 0, 0, 0, 0, "R2 hit youngest way");
    step(1, 1, 1, 0, 0, 0, 0, "R2 hit mid way");
    idle_on(1, "R4 victim after hits");

    // Invalidate, alone and overriding hit and fill.
    step(1, 0, 0, 0, 0, 1, 2, "R5 invalidate");
    step(1, 1, 0, 0, 0, 1, 3, "R5 invalidate beats hit");
    step(1, 0, 0, 1, 0, 1, 1, "R5 invalidate beats fill");
    idle_on(1, "R9 idle readout");

    // Failed fill.
    step(3, 0, 0, 1, 0, 0, 0, "R3 fill set3");
    step(3, 0, 0, 1, 0, 0, 0, "R3 fill set3 again");
    step(3, 0, 0, 1, 1, 0, 0, "R6 failed fill");
    idle_on(3, "R6 after failed fill");

    // Back-to-back ops on one set, then random mix.
    step(4, 0, 0, 1, 0, 0, 0, "R8 back to back a");
    step(4, 1, 0, 0, 0, 0, 0, "R8 back to back b");
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 5);
      step($urandom_range(0, SETS-1), op == 1, $urandom_range(0, WAYS-1),
           op == 2 || op == 3, op == 3, op == 4 || ($urandom_range(0, 7) == 0),
           $urandom_range(0, WAYS-1), "R7 random mix");
    end
    for (int s = 0; s < SETS; s++) idle_on(s, "R9 final sweep");

    @(negedge clk);
    hit_en = 0; fill_en = 0; inv_en = 0; fill_fail = 0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule